// File: doc/BRIEF.md
# Bus Error Logging Watcher

This block observes the outcome of completed bus transactions and keeps a record of data-error events so that diagnostic software can later work out what went wrong. For every transaction that fails, the fabric raises a one-cycle error strobe. The strobe comes with an error kind, the ID of the agent that sourced the data, the ID of the agent it was destined for, and a class bit. The class bit says whether the fault came from memory/IO or from the L2 cache. The error inputs are abstract, so any fault that reaches the bus marked as a data error is counted. This includes data that travelled with a valid address. The destination may be a CPU or a DMA engine.

Two saturating counters keep a separate tally for each error class. A single status word captures the details of the first error seen and then freezes. While it is frozen, the counters go on counting. An interrupt stays high while the status word holds a valid capture. Software reads the counters and the status word through a simple read port. Reading the status word clears it, which re-arms capture. Diagnostic code should therefore read the status word last.

Top module: `bus_err_logger`

## Requirements
- R1: After reset, both counters read 0, the status word reads 0 and `irq` is low.
- R2: Each cycle with `err_vld` high and `err_cls` = 0 (memory/IO) adds one to the memory/IO counter, read at `rd_addr` = 0. The L2 counter does not change.
- R3: Each cycle with `err_vld` high and `err_cls` = 1 (L2) adds one to the L2 counter, read at `rd_addr` = 1. The memory/IO counter does not change.
- R4: A counter that has reached 2^CNT_W-1 holds that value on further errors and never wraps.
- R5: An error that arrives while the status valid bit is clear is captured into the status word, read at `rd_addr` = 2. Bit 0 is the valid bit (1). Bits [3:1] hold the kind, bits [7:4] the source ID, bits [11:8] the destination ID and bit 12 the class. All higher bits are 0. Capture happens for every destination ID.
- R6: While the valid bit is set, further errors leave the status word unchanged, but they are still counted.
- R7: A read with `rd_en` high and `rd_addr` = 2 returns the status word in that cycle and clears it to 0 at the next clock edge. Reads of the counters have no side effect.
- R8: When an error arrives in the same cycle as a clearing read, the status word is still 0 after the edge, and the error is still counted.
- R9: `irq` is high exactly while the status valid bit is set. It rises in the cycle after a captured error and falls in the cycle after a clearing read.
- R10: `rd_data` is 0 when `rd_en` is low, and also for `rd_addr` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_vld | input | 1 | One failed transaction this cycle |
| err_kind | input | KIND_W | Error kind code |
| err_src | input | AGENT_W | Source agent ID |
| err_dst | input | AGENT_W | Destination agent ID (CPU or DMA) |
| err_cls | input | 1 | 0 = memory/IO, 1 = L2 |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 2 | 0 memory/IO count, 1 L2 count, 2 status (clear on read) |
| rd_data | output | DATA_W | Read data, combinational in the read cycle |
| irq | output | 1 | Error captured and not yet read |

## Verification
The capture path is tried with a sweep over every kind code, both classes and several destination IDs, one error and one clearing read at a time. This shows that each field reaches its own bit position and that no field is dropped or swapped. Bursts of back-to-back errors separate the frozen status word from the counters that keep running. Errors that coincide with a clearing read, both while the status is idle and while it is full, show the priority of the clear. Long runs of a single class push each counter to saturation, which separates holding at the maximum from wrapping and shows the other counter does not move.

// File: rtl/bel_pkg.sv
package bel_pkg;
    typedef enum logic [1:0] {
        SEL_MEMIO  = 2'd0,
        SEL_L2     = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } rd_sel_e;

    localparam int unsigned NUM_CLASSES = 2;
endpackage

// File: rtl/bel_sat_counter.sv
module bel_sat_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bel_status_reg.sv
module bel_status_reg #(
    parameter int unsigned KIND_W  = 3,
    parameter int unsigned AGENT_W = 4,
    localparam int unsigned STAT_W = 2 + KIND_W + 2 * AGENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_vld,
    input  logic [KIND_W-1:0] err_kind,
    input  logic [AGENT_W-1:0] err_src,
    input  logic [AGENT_W-1:0] err_dst,
    input  logic              err_cls,
    input  logic              clr,
    output logic [STAT_W-1:0] stat_word,
    output logic              stat_vld
);
    typedef struct packed {
        logic               cls;
        logic [AGENT_W-1:0] dst;
        logic [AGENT_W-1:0] src;
        logic [KIND_W-1:0]  kind;
        logic               vld;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (err_vld && !st_q.vld) begin
            st_d.vld  = 1'b1;
            st_d.kind = err_kind;
            st_d.src  = err_src;
            st_d.dst  = err_dst;
            st_d.cls  = err_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_word = st_q;
    assign stat_vld  = st_q.vld;
endmodule

// File: rtl/bel_read_mux.sv
module bel_read_mux
    import bel_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned STAT_W = 13,
    parameter int unsigned DATA_W = 32
) (
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    input  logic [CNT_W-1:0]  cnt_memio,
    input  logic [CNT_W-1:0]  cnt_l2,
    input  logic [STAT_W-1:0] stat_word,
    output logic [DATA_W-1:0] rd_data
);
    rd_sel_e sel;

    always_comb begin
        sel     = rd_sel_e'(rd_addr);
        rd_data = '0;
        if (rd_en) begin
            case (sel)
                SEL_MEMIO:  rd_data = DATA_W'(cnt_memio);
                SEL_L2:     rd_data = DATA_W'(cnt_l2);
                SEL_STATUS: rd_data = DATA_W'(stat_word);
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/bus_err_logger.sv
module bus_err_logger
    import bel_pkg::*;
#(
    parameter int unsigned KIND_W  = 3,
    parameter int unsigned AGENT_W = 4,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_vld,
    input  logic [KIND_W-1:0]  err_kind,
    input  logic [AGENT_W-1:0] err_src,
    input  logic [AGENT_W-1:0] err_dst,
    input  logic               err_cls,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);
    localparam int unsigned STAT_W = 2 + KIND_W + 2 * AGENT_W;

    logic [CNT_W-1:0]  cnt_q [NUM_CLASSES];
    logic [CNT_W-1:0]  cnt_memio;
    logic [CNT_W-1:0]  cnt_l2;
    logic [STAT_W-1:0] stat_word;
    logic              stat_vld;
    logic              clr_rd;

    assign clr_rd = rd_en && (rd_sel_e'(rd_addr) == SEL_STATUS);

    for (genvar gi = 0; gi < NUM_CLASSES; gi++) begin : g_cls
        bel_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (err_vld && (err_cls == gi[0])),
            .cnt   (cnt_q[gi])
        );
    end

    assign cnt_memio = cnt_q[0];
    assign cnt_l2    = cnt_q[1];

    bel_status_reg #(.KIND_W(KIND_W), .AGENT_W(AGENT_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_vld   (err_vld),
        .err_kind  (err_kind),
        .err_src   (err_src),
        .err_dst   (err_dst),
        .err_cls   (err_cls),
        .clr       (clr_rd),
        .stat_word (stat_word),
        .stat_vld  (stat_vld)
    );

    bel_read_mux #(.CNT_W(CNT_W), .STAT_W(STAT_W), .DATA_W(DATA_W)) u_rd (
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .cnt_memio (cnt_memio),
        .cnt_l2    (cnt_l2),
        .stat_word (stat_word),
        .rd_data   (rd_data)
    );

    assign irq = stat_vld;
endmodule

// File: rtl/bel_checker.sv
module bel_checker #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned STAT_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_vld,
    input logic              err_cls,
    input logic              rd_en,
    input logic [1:0]        rd_addr,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_memio,
    input logic [CNT_W-1:0]  cnt_l2,
    input logic [STAT_W-1:0] stat_word
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clr;
    assign clr = rd_en && (rd_addr == 2'd2);

    a_r2_memio_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !err_cls && cnt_memio != CMAX) |=> cnt_memio == CNT_W'($past(cnt_memio) + 1'b1));

    a_r3_l2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && err_cls && cnt_l2 != CMAX) |=> cnt_l2 == CNT_W'($past(cnt_l2) + 1'b1));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_memio == CMAX) |=> (cnt_memio == CMAX));

    a_r4_no_overflow_l2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_l2 == CMAX) |=> (cnt_l2 == CMAX));

    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> $stable(stat_word));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stat_word == '0 && !irq));

    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(err_vld) && !$past(clr)));
endmodule

bind bus_err_logger bel_checker #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_vld   (err_vld),
    .err_cls   (err_cls),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .irq       (irq),
    .cnt_memio (cnt_memio),
    .cnt_l2    (cnt_l2),
    .stat_word (stat_word)
);

// File: tb/bus_err_logger_bench.sv
`timescale 1ns/1ps
module bus_err_logger_bench;
    localparam int KW = 3, AW = 4, CW = 8, DW = 32;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_vld = 1'b0;
    logic [KW-1:0] err_kind = '0;
    logic [AW-1:0] err_src = '0, err_dst = '0;
    logic err_cls = 1'b0;
    logic rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic irq;

    int checks = 0, fails = 0;
    int exp_cnt [2];
    int exp_stat = 0;
    logic [DW-1:0] rd_seen;
    bit done = 0;

    always #4 clk = ~clk;

    bus_err_logger #(.KIND_W(KW), .AGENT_W(AW), .CNT_W(CW), .DATA_W(DW)) u_bus_err_logger (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_kind(err_kind),
        .err_src(err_src), .err_dst(err_dst), .err_cls(err_cls),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    function automatic int pack(int k, int s, int d, int c);
        return 1 + (k << 1) + (s << 4) + (d << 8) + (c << 12);
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // one clock: drive at negedge, sample read data mid-cycle, update model after edge
    task automatic cyc(bit e, int k, int s, int d, int c, bit r, int a);
        @(negedge clk);
        err_vld = e; err_kind = KW'(k); err_src = AW'(s); err_dst = AW'(d); err_cls = c[0];
        rd_en = r; rd_addr = 2'(a);
        #2 rd_seen = rd_data;
        @(posedge clk);
        if (e && exp_cnt[c] < CMAX) exp_cnt[c]++;
        if (r && a == 2) exp_stat = 0;
        else if (e && exp_stat == 0) exp_stat = pack(k, s, d, c);
        #1;
        err_vld = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd(int a, int exp, string req);
        cyc(0, 0, 0, 0, 0, 1, a);
        chk(req, int'(rd_seen), exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_cnt[0] = 0; exp_cnt[1] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        rd(0, 0, "R1 memio");
        rd(1, 0, "R1 l2");
        rd(2, 0, "R1 status");

        // R5/R9/R7 sweep over kind, class and destination
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 2; c++) begin
                for (int di = 0; di < 3; di++) begin
                    int d = (di == 0) ? 0 : (di == 1) ? 5 : 15;
                    int s = (k * 3 + c + di) & 15;
                    cyc(1, k, s, d, c, 0, 0);
                    #1 chk("R9 irq after capture", int'(irq), 1);
                    rd(2, pack(k, s, d, c), "R5 captured fields");
                    #1 chk("R7 irq after clearing read", int'(irq), 0);
                end
            end
        end
        rd(0, 24, "R2 memio count after sweep");
        rd(1, 24, "R3 l2 count after sweep");
        rd(0, 24, "R7 counter read has no side effect");

        // R6 frozen while counting continues
        cyc(1, 2, 9, 3, 0, 0, 0);
        cyc(1, 7, 1, 1, 1, 0, 0);
        cyc(1, 5, 4, 6, 0, 0, 0);
        rd(2, pack(2, 9, 3, 0), "R6 status holds first error");
        rd(0, 26, "R6 memio still counted");
        rd(1, 25, "R6 l2 still counted");

        // R8 error coinciding with clearing read, idle then full status
        cyc(1, 3, 3, 3, 1, 1, 2);
        chk("R8 read returns idle status", int'(rd_seen), 0);
        rd(2, 0, "R8 status empty after idle collision");
        cyc(1, 1, 2, 2, 0, 0, 0);
        cyc(1, 6, 6, 6, 0, 1, 2);
        chk("R8 read returns held status", int'(rd_seen), pack(1, 2, 2, 0));
        rd(2, 0, "R8 status empty after full collision");
        rd(0, 28, "R8 colliding errors counted memio");
        rd(1, 26, "R8 colliding errors counted l2");

        // R10 read gating and unused address
        cyc(1, 4, 4, 4, 1, 0, 0);
        @(negedge clk); rd_en = 1'b0; rd_addr = 2'd2; #1;
        chk("R10 rd_data with rd_en low", int'(rd_data), 0);
        rd(3, 0, "R10 unused address");
        rd(2, pack(4, 4, 4, 1), "R10 status untouched by gated read");

        // R4 saturation on each class
        for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, 0, 0, 0);
        rd(0, CMAX, "R4 memio saturates");
        rd(1, 27, "R2 l2 unaffected by memio burst");
        for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, 1, 0, 0);
        rd(1, CMAX, "R4 l2 saturates");
        rd(0, CMAX, "R3 memio unaffected by l2 burst");
        chk("R4 model consistency", exp_cnt[0] + exp_cnt[1], 2 * CMAX);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule